// File: doc/BRIEF.md
# PLL Feedback Divider Word Selector

This block picks the feedback divider words for two clock PLLs. The first PLL drives the processor clock. The second PLL drives a serial reference clock.

For the processor PLL, the starting divider pair comes from one of three places:

- a 4-bit strap code;
- a 4-bit software table index, which takes over from the strap code when an override bit is set;
- a directly programmed N/M pair held in shadow registers.

A 3-bit pin code can then add an offset to N. A 3-bit limit field caps how large that offset may grow, so a programmed start combined with a large dynamic step cannot run the clock away. The reference PLL takes only a programmed N, under its own enable. Its M is fixed.

Register writes arrive as parallel data with write strobes and land in shadow registers. All outputs are registered. The active table index is also driven out, so a neighbouring gear lookup can use it.

Top module: `pll_div_select`

## Requirements
- R1: While rst_ni is low, every output is 0 and every shadow register is cleared to 0.
- R2: gear_idx_o equals sw_sel_i when fs_ovr_i is 1. It equals strap_i when fs_ovr_i is 0.
- R3: When cpu_prog_en_i is 0, the base CPU N is 100 + 10*idx and the base CPU M is 20 + idx, where idx is the active table index.
- R4: When cpu_prog_en_i is 1, the base CPU N and M come from the shadow registers. A cycle with cpu_n_we_i high loads the N shadow from cpu_n_d_i. The M shadow loads from cpu_m_d_i only in a cycle where cpu_n_we_i and cpu_m_we_i are both high. A write with cpu_m_we_i high and cpu_n_we_i low is ignored.
- R5: When dyn_en_i is 1, the pin code dyn_code_i adds an offset to the base N. The codes 0 to 7 give +0, +2, +6, +10, +14, +18, +30 and +40 in that order. The offset applies to any base: strap, software table or programmed. When dyn_en_i is 0, the offset is 0.
- R6: The offset actually applied is the smaller of the R5 offset and the R5 table entry at code limit_i. The sum is saturated at 511. cpu_m_o is the base M and is never changed by the offset.
- R7: ref_n_o is the reference N shadow when ref_prog_en_i is 1, and 100 otherwise. The shadow loads from ref_n_d_i when ref_n_we_i is high. ref_m_o is always 24 outside reset.
- R8: A change on a control input appears on the outputs at the next rising clock edge. A register write appears at the second rising edge, because it passes through the shadow register first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| strap_i | input | 4 | Hardware strap table code |
| sw_sel_i | input | 4 | Software table index |
| fs_ovr_i | input | 1 | Selects the software index instead of the strap code |
| cpu_prog_en_i | input | 1 | Use the programmed CPU N/M pair |
| cpu_n_we_i | input | 1 | CPU N shadow write strobe |
| cpu_n_d_i | input | 9 | CPU N write data |
| cpu_m_we_i | input | 1 | CPU M shadow write strobe (effective only together with N) |
| cpu_m_d_i | input | 7 | CPU M write data |
| ref_prog_en_i | input | 1 | Use the programmed reference N |
| ref_n_we_i | input | 1 | Reference N shadow write strobe |
| ref_n_d_i | input | 9 | Reference N write data |
| dyn_en_i | input | 1 | Dynamic offset enable |
| dyn_code_i | input | 3 | Dynamic offset pin code |
| limit_i | input | 3 | Offset ceiling code |
| cpu_n_o | output | 9 | Effective CPU feedback N |
| cpu_m_o | output | 7 | Effective CPU M |
| ref_n_o | output | 9 | Effective reference N |
| ref_m_o | output | 7 | Reference M (fixed) |
| gear_idx_o | output | 4 | Active table index |

## Verification
A corrupted shadow register stays hidden while the table path is selected. It appears on cpu_n_o or cpu_m_o at the first edge after cpu_prog_en_i rises, so the bench toggles that enable often and reads the shadows back through it. A wrong offset or clamp entry shows on cpu_n_o only for the codes that hit it, so random codes and limits are mixed with directed saturation cases. A mistimed register appears as a one-cycle skew against the bench's model on every output.

// File: rtl/pll_div_pkg.sv
package pll_div_pkg;
  localparam int N_W    = 9;
  localparam int M_W    = 7;
  localparam int IDX_W  = 4;
  localparam int CODE_W = 3;
  localparam int OFS_W  = 6;

  function automatic logic [OFS_W-1:0] dyn_step(input logic [CODE_W-1:0] c);
    case (c)
      3'd0:    return 6'd0;
      3'd1:    return 6'd2;
      3'd2:    return 6'd6;
      3'd3:    return 6'd10;
      3'd4:    return 6'd14;
      3'd5:    return 6'd18;
      3'd6:    return 6'd30;
      default: return 6'd40;
    endcase
  endfunction
endpackage

// File: rtl/pll_div_shadow.sv
module pll_div_shadow
  import pll_div_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           cpu_n_we_i,
  input  logic [N_W-1:0] cpu_n_d_i,
  input  logic           cpu_m_we_i,
  input  logic [M_W-1:0] cpu_m_d_i,
  input  logic           ref_n_we_i,
  input  logic [N_W-1:0] ref_n_d_i,
  output logic [N_W-1:0] sh_cpu_n_o,
  output logic [M_W-1:0] sh_cpu_m_o,
  output logic [N_W-1:0] sh_ref_n_o
);
  logic m_load;
  assign m_load = cpu_n_we_i & cpu_m_we_i;  // M moves only with N

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_cpu_n_o <= '0;
      sh_cpu_m_o <= '0;
      sh_ref_n_o <= '0;
    end else begin
      if (cpu_n_we_i) sh_cpu_n_o <= cpu_n_d_i;
      if (m_load)     sh_cpu_m_o <= cpu_m_d_i;
      if (ref_n_we_i) sh_ref_n_o <= ref_n_d_i;
    end
  end

  a_r4_m_needs_n: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_n_we_i |=> $stable(sh_cpu_m_o));
  a_r4_n_alone: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_n_we_i |=> sh_cpu_n_o == $past(cpu_n_d_i));
  a_r7_ref_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_n_we_i |=> $stable(sh_ref_n_o));
endmodule

// File: rtl/pll_div_cpu_path.sv
module pll_div_cpu_path
  import pll_div_pkg::*;
#(
  parameter int TAB_N_BASE = 100,
  parameter int TAB_N_STEP = 10,
  parameter int TAB_M_BASE = 20
) (
  input  logic              fs_ovr_i,
  input  logic [IDX_W-1:0]  strap_i,
  input  logic [IDX_W-1:0]  sw_sel_i,
  input  logic              prog_en_i,
  input  logic [N_W-1:0]    sh_n_i,
  input  logic [M_W-1:0]    sh_m_i,
  input  logic              dyn_en_i,
  input  logic [CODE_W-1:0] dyn_code_i,
  input  logic [CODE_W-1:0] limit_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [N_W-1:0]    base_n_o,
  output logic [M_W-1:0]    base_m_o,
  output logic [N_W-1:0]    n_o
);
  localparam int SUM_W = N_W + 1;
  localparam logic [SUM_W-1:0] N_MAX = SUM_W'((1 << N_W) - 1);

  logic [N_W-1:0]   tab_n;
  logic [M_W-1:0]   tab_m;
  logic [OFS_W-1:0] ofs_req, ofs_cap, ofs_eff;
  logic [SUM_W-1:0] sum;

  always_comb begin
    idx_o    = fs_ovr_i ? sw_sel_i : strap_i;
    tab_n    = N_W'(TAB_N_BASE + TAB_N_STEP * int'(idx_o));
    tab_m    = M_W'(TAB_M_BASE + int'(idx_o));
    base_n_o = prog_en_i ? sh_n_i : tab_n;
    base_m_o = prog_en_i ? sh_m_i : tab_m;
    ofs_req  = dyn_en_i ? dyn_step(dyn_code_i) : '0;
    ofs_cap  = dyn_step(limit_i);
    ofs_eff  = (ofs_req > ofs_cap) ? ofs_cap : ofs_req;
    sum      = SUM_W'(base_n_o) + SUM_W'(ofs_eff);
    n_o      = (sum > N_MAX) ? N_W'(N_MAX) : sum[N_W-1:0];
  end
endmodule

// File: rtl/pll_div_select.sv
module pll_div_select
  import pll_div_pkg::*;
#(
  parameter int TAB_N_BASE = 100,
  parameter int TAB_N_STEP = 10,
  parameter int TAB_M_BASE = 20,
  parameter int REF_N_DEF  = 100,
  parameter int REF_M_FIX  = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  strap_i,
  input  logic [IDX_W-1:0]  sw_sel_i,
  input  logic              fs_ovr_i,
  input  logic              cpu_prog_en_i,
  input  logic              cpu_n_we_i,
  input  logic [N_W-1:0]    cpu_n_d_i,
  input  logic              cpu_m_we_i,
  input  logic [M_W-1:0]    cpu_m_d_i,
  input  logic              ref_prog_en_i,
  input  logic              ref_n_we_i,
  input  logic [N_W-1:0]    ref_n_d_i,
  input  logic              dyn_en_i,
  input  logic [CODE_W-1:0] dyn_code_i,
  input  logic [CODE_W-1:0] limit_i,
  output logic [N_W-1:0]    cpu_n_o,
  output logic [M_W-1:0]    cpu_m_o,
  output logic [N_W-1:0]    ref_n_o,
  output logic [M_W-1:0]    ref_m_o,
  output logic [IDX_W-1:0]  gear_idx_o
);
  logic [N_W-1:0]   sh_cpu_n, sh_ref_n, base_n, nxt_n;
  logic [M_W-1:0]   sh_cpu_m, base_m;
  logic [IDX_W-1:0] idx;

  pll_div_shadow u_shadow (
    .clk_i, .rst_ni,
    .cpu_n_we_i, .cpu_n_d_i, .cpu_m_we_i, .cpu_m_d_i,
    .ref_n_we_i, .ref_n_d_i,
    .sh_cpu_n_o(sh_cpu_n), .sh_cpu_m_o(sh_cpu_m), .sh_ref_n_o(sh_ref_n)
  );

  pll_div_cpu_path #(
    .TAB_N_BASE(TAB_N_BASE), .TAB_N_STEP(TAB_N_STEP), .TAB_M_BASE(TAB_M_BASE)
  ) u_cpu (
    .fs_ovr_i, .strap_i, .sw_sel_i,
    .prog_en_i(cpu_prog_en_i), .sh_n_i(sh_cpu_n), .sh_m_i(sh_cpu_m),
    .dyn_en_i, .dyn_code_i, .limit_i,
    .idx_o(idx), .base_n_o(base_n), .base_m_o(base_m), .n_o(nxt_n)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cpu_n_o    <= '0;
      cpu_m_o    <= '0;
      ref_n_o    <= '0;
      ref_m_o    <= '0;
      gear_idx_o <= '0;
    end else begin
      cpu_n_o    <= nxt_n;
      cpu_m_o    <= base_m;
      ref_n_o    <= ref_prog_en_i ? sh_ref_n : N_W'(REF_N_DEF);
      ref_m_o    <= M_W'(REF_M_FIX);
      gear_idx_o <= idx;
    end
  end

  a_r2_sw_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fs_ovr_i |=> gear_idx_o == $past(sw_sel_i));
  a_r2_strap_index: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fs_ovr_i |=> gear_idx_o == $past(strap_i));
  a_r5_no_offset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dyn_en_i |=> cpu_n_o == $past(base_n));
  a_r6_never_below: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cpu_n_o >= $past(base_n));
  a_r6_step_cap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (10'(cpu_n_o) - 10'($past(base_n))) <= 10'(dyn_step($past(limit_i))));
  a_r6_m_untouched: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> cpu_m_o == $past(base_m));
endmodule

// File: tb/sim_pll_div_select.sv
module sim_pll_div_select;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [3:0] strap = 0, sw_sel = 0;
  logic fs_ovr = 0, cpu_prog_en = 0, cpu_n_we = 0, cpu_m_we = 0;
  logic ref_prog_en = 0, ref_n_we = 0, dyn_en = 0;
  logic [8:0] cpu_n_d = 0, ref_n_d = 0;
  logic [6:0] cpu_m_d = 0;
  logic [2:0] dyn_code = 0, limit = 0;
  logic [8:0] cpu_n, ref_n;
  logic [6:0] cpu_m, ref_m;
  logic [3:0] gear_idx;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model state
  logic [8:0] m_sh_n = 0, m_sh_ref = 0;
  logic [6:0] m_sh_m = 0;
  logic [8:0] e_cpu_n = 0, e_ref_n = 0;
  logic [6:0] e_cpu_m = 0, e_ref_m = 0;
  logic [3:0] e_idx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pll_div_select u0 (
    .clk_i(clk), .rst_ni(rst_n), .strap_i(strap), .sw_sel_i(sw_sel),
    .fs_ovr_i(fs_ovr), .cpu_prog_en_i(cpu_prog_en), .cpu_n_we_i(cpu_n_we),
    .cpu_n_d_i(cpu_n_d), .cpu_m_we_i(cpu_m_we), .cpu_m_d_i(cpu_m_d),
    .ref_prog_en_i(ref_prog_en), .ref_n_we_i(ref_n_we), .ref_n_d_i(ref_n_d),
    .dyn_en_i(dyn_en), .dyn_code_i(dyn_code), .limit_i(limit),
    .cpu_n_o(cpu_n), .cpu_m_o(cpu_m), .ref_n_o(ref_n), .ref_m_o(ref_m),
    .gear_idx_o(gear_idx)
  );

  function automatic int ofs(input logic [2:0] c);
    int t[8] = '{0, 2, 6, 10, 14, 18, 30, 40};
    return t[c];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // one clock: model the edge, then compare at the following falling edge
  task automatic step();
    int idx, bn, bm, add, s;
    @(posedge clk);
    idx = fs_ovr ? sw_sel : strap;
    bn  = cpu_prog_en ? m_sh_n : 100 + 10*idx;
    bm  = cpu_prog_en ? m_sh_m : 20 + idx;
    add = dyn_en ? ofs(dyn_code) : 0;
    if (add > ofs(limit)) add = ofs(limit);
    s = bn + add;
    if (s > 511) s = 511;
    e_idx = 4'(idx); e_cpu_n = 9'(s); e_cpu_m = 7'(bm);
    e_ref_n = ref_prog_en ? m_sh_ref : 9'd100; e_ref_m = 7'd24;
    if (cpu_n_we) m_sh_n = cpu_n_d;
    if (cpu_n_we && cpu_m_we) m_sh_m = cpu_m_d;
    if (ref_n_we) m_sh_ref = ref_n_d;
    @(negedge clk);
    chk("R2", gear_idx, e_idx);
    chk("R5/R6 cpu_n", cpu_n, e_cpu_n);
    chk("R3/R4 cpu_m", cpu_m, e_cpu_m);
    chk("R7 ref_n", ref_n, e_ref_n);
    chk("R7 ref_m", ref_m, e_ref_m);
  endtask

  task automatic quiet();
    cpu_n_we = 0; cpu_m_we = 0; ref_n_we = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1357));
    strap = 4'd5; cpu_n_we = 1; cpu_n_d = 9'd300;
    #(CLK_PERIOD*3);
    // R1: reset state, writes blocked
    chk("R1 cpu_n", cpu_n, 0); chk("R1 cpu_m", cpu_m, 0);
    chk("R1 ref", ref_n + ref_m, 0); chk("R1 idx", gear_idx, 0);
    quiet();
    @(negedge clk); rst_n = 1;
    // R3: strap table
    step();
    // R1: shadow cleared -> programmed path shows 0
    cpu_prog_en = 1; ref_prog_en = 1; step();
    chk("R1 shadow n", cpu_n, 0); chk("R1 shadow ref", ref_n, 0);
    // R4: M write without N is ignored
    cpu_m_we = 1; cpu_m_d = 7'd99; step(); quiet(); step();
    chk("R4 m ignored", cpu_m, 0);
    // R4: N alone, then N+M
    cpu_n_we = 1; cpu_n_d = 9'd250; step(); quiet(); step();
    chk("R4 n alone", cpu_n, 250);
    cpu_n_we = 1; cpu_m_we = 1; cpu_n_d = 9'd505; cpu_m_d = 7'd33; step(); quiet();
    // R8: write reaches outputs on the second edge
    chk("R8 write latency", cpu_n, 250);
    step(); chk("R4 n+m", cpu_m, 33);
    // R6: saturation 505+40 -> 511
    dyn_en = 1; dyn_code = 3'd7; limit = 3'd7; step();
    chk("R6 saturate", cpu_n, 511);
    // R6: ceiling at limit code 2 (+6)
    cpu_prog_en = 0; fs_ovr = 1; sw_sel = 4'd3; limit = 3'd2; step();
    chk("R6 clamp", cpu_n, 130 + 6);
    // R5: offset on software table
    limit = 3'd7; dyn_code = 3'd4; step();
    chk("R5 table offset", cpu_n, 144);
    // R7: reference default
    ref_prog_en = 0; step(); chk("R7 ref default", ref_n, 100);
    // R8: control change appears at next edge
    @(negedge clk); sw_sel = 4'd9; @(posedge clk); #1;
    chk("R8 control latency", gear_idx, 9);
    @(negedge clk);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      strap = 4'($urandom); sw_sel = 4'($urandom); fs_ovr = 1'($urandom);
      cpu_prog_en = 1'($urandom); ref_prog_en = 1'($urandom);
      dyn_en = 1'($urandom); dyn_code = 3'($urandom); limit = 3'($urandom);
      cpu_n_we = ($urandom % 4) == 0; cpu_m_we = 1'($urandom);
      ref_n_we = ($urandom % 4) == 0;
      cpu_n_d = 9'($urandom); cpu_m_d = 7'($urandom); ref_n_d = 9'($urandom);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule